// File: doc/BRIEF.md
# EDO DRAM Data-Output Enable Control

This block is a clock-by-clock behavioural model of the logic that decides whether the data pins of an EDO DRAM are driven. It samples the four active-low strobes (row strobe, column strobe, output enable and write enable) on every rising clock edge. From them it produces a registered drive enable, the gated read data and a status flag. The data to be driven comes from an input port. The memory array, the address path and refresh are not part of this block.

The output behaves as an extended-data-out driver. It turns on while the column strobe is low with output enable low and write enable high. It keeps driving after the column strobe returns high, until one of the following turns it off:
- an output-enable pulse while the column strobe is high,
- both strobes being high for a set time,
- write enable being low for a set time.

An output-enable pulse leaves the driver latched off until the column strobe falls again. All delays are parameters counted in clock cycles.

Top module: `edo_dq_enable`

## Requirements
- R1: A synchronous active-high reset leaves `dq_oe` at 0, `sticky_off` at 0 and `dq_out` at all zeros.
- R2: After an edge that samples `cas_n`=0, `oe_n`=0 and `we_n`=1, `dq_oe` is 1. While `dq_oe` is 1, `dq_out` equals `din`. While `dq_oe` is 0, `dq_out` is all zeros.
- R3: While `cas_n` is sampled low, an edge that samples `oe_n`=1 clears `dq_oe`.
- R4: Suppose `oe_n` is 1 at the edge where `cas_n` is first sampled high, and stays 1 with `cas_n` high for HOLD_OE consecutive edges, counting that first edge. After the last of those edges, `dq_oe` is 0 and `sticky_off` is 1.
- R5: Suppose `oe_n` is 0 at the edge where `cas_n` is first sampled high, and later `oe_n` is 1 for PULSE_OE consecutive edges while `cas_n` stays high. After the last of those edges, `dq_oe` is 0 and `sticky_off` is 1.
- R6: While `sticky_off` is 1 and `cas_n` stays high, `sticky_off` stays 1 and `dq_oe` stays 0, whatever `oe_n` does. The first edge that samples `cas_n` low after a high sample clears `sticky_off`.
- R7: An `oe_n` high run during `cas_n` high that is shorter than its threshold neither clears `dq_oe` nor sets `sticky_off`.
- R8: When `ras_n` and `cas_n` are both sampled high for DLY_OFF consecutive edges, `dq_oe` is 0 after the last of those edges. The count starts at the edge where the later of the two strobes is first sampled high.
- R9: When `we_n` is sampled low for DLY_WZ consecutive edges, `dq_oe` is 0 after the last of them, and it stays 0 while `we_n` stays low. `we_n` low never turns the driver on.
- R10: An edge that samples `cas_n` high never changes `dq_oe` from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| din | input | DW | Read data to be placed on the pins |
| dq_oe | output | 1 | Registered drive enable for the data pins |
| dq_out | output | DW | `din` while driving, zeros otherwise |
| sticky_off | output | 1 | Set while an output-enable pulse keeps the driver latched off |

## Verification
The strobes are driven through several sequences:
- a plain read turn-on followed by an output-enable release while the column strobe is low;
- a column-strobe rise with output enable high (the hold path) and one with output enable low followed by a late pulse;
- runs one cycle shorter than each threshold, to show that the count, and not the mere level, makes the decision;
- both strobes high, and write enable low with and without the column strobe low.

The hold and pulse sequences are kept apart so that swapping the two thresholds shows up. After each latch-off, output enable is brought low again while the column strobe stays high, which separates a sticky latch from a plain level-following enable.

// File: rtl/edo_dq_pkg.sv
package edo_dq_pkg;
  typedef int unsigned cnt_t;

  // Next value of a saturating run counter: restarts at zero when the run breaks.
  function automatic cnt_t run_next(cnt_t cur, logic hit, cnt_t lim);
    if (!hit) return 0;
    if (cur >= lim) return lim;
    return cur + 1;
  endfunction

  // A run has lasted long enough once its length meets the limit.
  function automatic logic run_done(cnt_t len, cnt_t lim);
    return (len >= lim);
  endfunction

  function automatic cnt_t max2(cnt_t a, cnt_t b);
    return (a > b) ? a : b;
  endfunction

  function automatic cnt_t cnt_bits(cnt_t lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/edo_edge_detect.sv
module edo_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic sig_n,
  output logic went_high,
  output logic went_low
);
  logic last_q;

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= sig_n;
  end

  assign went_high = sig_n & ~last_q;
  assign went_low  = ~sig_n & last_q;

  // R6: a falling sample cannot be followed directly by another falling sample
  assert_no_double_fall_R6: assert property (@(posedge clk) disable iff (rst)
    went_low |=> !went_low);
endmodule

// File: rtl/edo_run_counter.sv
module edo_run_counter #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic reached
);
  import edo_dq_pkg::*;
  localparam int unsigned CW = cnt_bits(LIMIT);

  logic [CW-1:0] cnt_q;
  cnt_t          nxt;

  always_comb begin
    nxt     = run_next(cnt_t'(cnt_q), hit, LIMIT);
    reached = run_done(nxt, LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= CW'(nxt);
  end

  // R8/R9: once the limit is met, an unbroken run keeps it met
  assert_run_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (reached && hit) |=> (!hit || reached));
endmodule

// File: rtl/edo_oe_latch.sv
module edo_oe_latch #(
  parameter int unsigned HOLD_OE  = 2,
  parameter int unsigned PULSE_OE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic cas_n,
  input  logic oe_n,
  input  logic cas_rise,
  input  logic cas_fall,
  output logic trip,
  output logic sticky
);
  import edo_dq_pkg::*;
  localparam cnt_t TOP = max2(HOLD_OE, PULSE_OE);
  localparam int unsigned CW = cnt_bits(TOP);

  logic [CW-1:0] run_q;
  logic          from_rise_q;
  logic          in_run;
  cnt_t          run_nx;
  logic          from_rise_nx;
  cnt_t          thresh;

  assign in_run = cas_n & oe_n;

  always_comb begin
    run_nx       = run_next(cnt_t'(run_q), in_run, TOP);
    from_rise_nx = 1'b0;
    if (in_run) from_rise_nx = (run_q == '0) ? cas_rise : from_rise_q;
    thresh = from_rise_nx ? HOLD_OE : PULSE_OE;
    trip   = in_run & run_done(run_nx, thresh);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= '0;
      from_rise_q <= 1'b0;
      sticky      <= 1'b0;
    end else begin
      run_q       <= CW'(run_nx);
      from_rise_q <= from_rise_nx;
      if (cas_fall)  sticky <= 1'b0;
      else if (trip) sticky <= 1'b1;
    end
  end

  // R6: the latch is held while the column strobe stays high
  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (sticky && cas_n) |=> sticky);
  // R6: a falling column strobe releases the latch
  assert_sticky_clear_R6: assert property (@(posedge clk) disable iff (rst)
    cas_fall |=> !sticky);
endmodule

// File: rtl/edo_dq_enable.sv
module edo_dq_enable #(
  parameter int unsigned DW       = 16,
  parameter int unsigned HOLD_OE  = 2,
  parameter int unsigned PULSE_OE = 3,
  parameter int unsigned DLY_OFF  = 2,
  parameter int unsigned DLY_WZ   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [DW-1:0] din,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out,
  output logic          sticky_off
);
  logic cas_rise, cas_fall;
  logic oe_trip;
  logic we_blk, hi_blk;
  logic drv_nx;

  edo_edge_detect u_cas_edge (
    .clk(clk), .rst(rst), .sig_n(cas_n),
    .went_high(cas_rise), .went_low(cas_fall)
  );

  edo_run_counter #(.LIMIT(DLY_WZ)) u_we_run (
    .clk(clk), .rst(rst), .hit(~we_n), .reached(we_blk)
  );

  edo_run_counter #(.LIMIT(DLY_OFF)) u_hi_run (
    .clk(clk), .rst(rst), .hit(ras_n & cas_n), .reached(hi_blk)
  );

  edo_oe_latch #(.HOLD_OE(HOLD_OE), .PULSE_OE(PULSE_OE)) u_oe_latch (
    .clk(clk), .rst(rst), .cas_n(cas_n), .oe_n(oe_n),
    .cas_rise(cas_rise), .cas_fall(cas_fall),
    .trip(oe_trip), .sticky(sticky_off)
  );

  // Column strobe low: output enable follows, a write run blocks, turn-on needs a read.
  // Column strobe high: the driver can only be kept or dropped.
  always_comb begin
    if (!cas_n) drv_nx = ~oe_n & ~we_blk & (dq_oe | we_n);
    else        drv_nx = dq_oe & ~oe_trip & ~hi_blk & ~we_blk;
  end

  always_ff @(posedge clk) begin
    if (rst) dq_oe <= 1'b0;
    else     dq_oe <= drv_nx;
  end

  for (genvar b = 0; b < DW; b++) begin : g_gate
    assign dq_out[b] = dq_oe & din[b];
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!dq_oe && !sticky_off));
  assert_read_on_R2: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && !oe_n && we_n) |=> dq_oe);
  assert_oe_release_R3: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && oe_n) |=> !dq_oe);
  assert_latched_off_R6: assert property (@(posedge clk) disable iff (rst)
    sticky_off |-> !dq_oe);
  assert_both_high_off_R8: assert property (@(posedge clk) disable iff (rst)
    hi_blk |=> !dq_oe);
  assert_write_off_R9: assert property (@(posedge clk) disable iff (rst)
    we_blk |=> !dq_oe);
  assert_no_turn_on_R10: assert property (@(posedge clk) disable iff (rst)
    (cas_n && !dq_oe) |=> !dq_oe);
endmodule

// File: tb/sim_edo_dq_enable.sv
`timescale 1ns/1ps
module sim_edo_dq_enable;
  localparam int DW = 8;
  localparam int HOLD = 2, PULSE = 3, TOFF = 2, TWZ = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [DW-1:0] din = 8'hA5;
  logic dq_oe, sticky_off;
  logic [DW-1:0] dq_out;

  always #2 clk = ~clk;

  edo_dq_enable #(.DW(DW), .HOLD_OE(HOLD), .PULSE_OE(PULSE),
                  .DLY_OFF(TOFF), .DLY_WZ(TWZ)) u0 (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
    .we_n(we_n), .din(din), .dq_oe(dq_oe), .dq_out(dq_out),
    .sticky_off(sticky_off)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  // Behavioural reference: plain integer run lengths, no saturation
  int  w_len = 0, h_len = 0, o_len = 0;
  bit  o_from_rise = 0, last_cas = 1, m_drv = 0, m_stk = 0;

  always @(posedge clk) begin
    if (rst) begin
      w_len = 0; h_len = 0; o_len = 0; o_from_rise = 0;
      last_cas = 1; m_drv = 0; m_stk = 0;
    end else begin
      bit rise, fall, trip;
      int need;
      rise = cas_n && !last_cas;
      fall = !cas_n && last_cas;
      w_len = we_n ? 0 : w_len + 1;
      h_len = (ras_n && cas_n) ? h_len + 1 : 0;
      if (cas_n && oe_n) begin
        if (o_len == 0) o_from_rise = rise;
        o_len = o_len + 1;
      end else begin
        o_len = 0; o_from_rise = 0;
      end
      need = o_from_rise ? HOLD : PULSE;
      trip = cas_n && oe_n && (o_len >= need);
      if (fall) m_stk = 0;
      else if (trip) m_stk = 1;
      if (!cas_n) m_drv = !oe_n && (w_len < TWZ) && (m_drv || we_n);
      else        m_drv = m_drv && !trip && (h_len < TOFF) && (w_len < TWZ);
      last_cas = cas_n;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic c, input logic o, input logic w,
                      input logic [DW-1:0] d);
    ras_n = r; cas_n = c; oe_n = o; we_n = w; din = d;
    @(posedge clk); #1;
    check({tag, " dq_oe"}, 32'(dq_oe), 32'(m_drv));
    check({tag, " sticky_off"}, 32'(sticky_off), 32'(m_stk));
    check({tag, " dq_out"}, 32'(dq_out), m_drv ? 32'(din) : 32'd0);
  endtask

  initial begin
    repeat (3) step(1, 1, 1, 1, 8'hA5);
    check("R1 reset dq_oe", 32'(dq_oe), 0);
    check("R1 reset sticky", 32'(sticky_off), 0);
    check("R1 reset dq_out", 32'(dq_out), 0);
    rst = 1'b0;
    step(1, 1, 1, 1, 8'hA5);

    tag = "R2";
    step(0, 1, 0, 1, 8'h11);
    step(0, 0, 0, 1, 8'h3C);
    check("R2 on", 32'(dq_oe), 1);
    check("R2 data", 32'(dq_out), 32'h3C);
    step(0, 0, 0, 1, 8'hC3);
    check("R2 data follows", 32'(dq_out), 32'hC3);

    tag = "R3";
    step(0, 0, 1, 1, 8'h55);
    check("R3 oe release", 32'(dq_oe), 0);
    check("R2 zero when off", 32'(dq_out), 0);
    step(0, 0, 0, 1, 8'h55);
    check("R3 back on", 32'(dq_oe), 1);

    tag = "R4";
    step(0, 1, 1, 1, 8'h66);
    check("R4 one short of hold", 32'(dq_oe), 1);
    step(0, 1, 1, 1, 8'h66);
    check("R4 off", 32'(dq_oe), 0);
    check("R4 sticky", 32'(sticky_off), 1);
    tag = "R6";
    step(0, 1, 0, 1, 8'h66);
    step(0, 1, 0, 1, 8'h66);
    check("R6 stays off oe low", 32'(dq_oe), 0);
    check("R6 sticky held", 32'(sticky_off), 1);
    step(0, 0, 0, 1, 8'h77);
    check("R6 cleared on cas fall", 32'(sticky_off), 0);
    check("R6 reenabled", 32'(dq_oe), 1);

    tag = "R5";
    step(0, 1, 0, 1, 8'h12);
    step(0, 1, 1, 1, 8'h12);
    step(0, 1, 1, 1, 8'h12);
    check("R5 two of three", 32'(dq_oe), 1);
    step(0, 1, 1, 1, 8'h12);
    check("R5 off", 32'(dq_oe), 0);
    check("R5 sticky", 32'(sticky_off), 1);
    step(0, 1, 0, 1, 8'h12);
    check("R6 after pulse", 32'(dq_oe), 0);
    step(0, 0, 0, 1, 8'h21);
    check("R6 on again", 32'(dq_oe), 1);

    tag = "R7";
    step(0, 1, 1, 1, 8'h34);
    step(0, 1, 0, 1, 8'h34);
    step(0, 1, 1, 1, 8'h34);
    step(0, 1, 1, 1, 8'h34);
    step(0, 1, 0, 1, 8'h34);
    check("R7 short runs keep drive", 32'(dq_oe), 1);
    check("R7 no sticky", 32'(sticky_off), 0);

    tag = "R8";
    step(0, 0, 0, 1, 8'h9A);
    step(1, 0, 0, 1, 8'h9A);
    step(1, 0, 0, 1, 8'h9A);
    check("R8 ras high cas low", 32'(dq_oe), 1);
    step(1, 1, 0, 1, 8'h9A);
    check("R8 counted from later rise", 32'(dq_oe), 1);
    step(1, 1, 0, 1, 8'h9A);
    check("R8 off", 32'(dq_oe), 0);
    tag = "R10";
    step(0, 1, 0, 1, 8'h9A);
    step(0, 1, 0, 1, 8'h9A);
    check("R10 no turn-on cas high", 32'(dq_oe), 0);

    tag = "R9";
    step(0, 0, 0, 1, 8'hBE);
    step(0, 0, 0, 0, 8'hBE);
    check("R9 one write cycle", 32'(dq_oe), 1);
    step(0, 0, 0, 0, 8'hBE);
    check("R9 off", 32'(dq_oe), 0);
    step(0, 0, 0, 0, 8'hBE);
    check("R9 stays off", 32'(dq_oe), 0);
    step(0, 0, 0, 1, 8'hBE);
    check("R9 on after write", 32'(dq_oe), 1);
    step(0, 1, 0, 0, 8'hBE);
    step(0, 0, 0, 0, 8'hBE);
    check("R9 write low no turn-on", 32'(dq_oe), 0);
    step(1, 1, 1, 1, 8'h00);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule